// File: doc/BRIEF.md
# Fixed-Point DSP ALU with Status Flags

This block is the arithmetic and logic stage of a small fixed-point signal processor. Each cycle in which the execute strobe is high it combines a 48-bit accumulator operand with a 48-bit product operand under a 4-bit operation code. It registers a 48-bit result for the accumulator-load path and updates four status flags: carry, zero, sign and a sticky overflow flag.

Most operations act on the low 32-bit word: bitwise logic, add, subtract, single-bit shifts and rotates, and a byte rotate. For these, the upper 16 bits pass through from the accumulator. One operation is a full 48-bit add, used for accumulation. The overflow flag collects signed overflow from every add and subtract until a separate clear input drops it. The asynchronous active-low reset is released into the block through a two-stage synchronizer.

Top module: `dsp_alu_core`

## Requirements
- R1: Codes 0, 7, 0xC, 0xD and 0xE (and any code not listed in R2 to R8) are no-ops: the registered result becomes the accumulator input unchanged and carry, zero and sign keep their values.
- R2: Code 1 (AND), 2 (OR) and 3 (XOR) combine bits 31:0 of both operands, clear carry, set zero when the 32-bit result is 0 and set sign from result bit 31.
- R3: Code 4 adds and code 5 subtracts (accumulator minus product) on bits 31:0. Carry is bit 32 of the zero-extended result, so for subtract it is 1 exactly when the accumulator word is below the product word as unsigned numbers. Zero and sign come from the 32-bit result.
- R4: Overflow is sticky. For add it is set when both operands have equal sign bits and the result sign differs. For subtract it is set when the operand signs differ and the result sign differs from the accumulator's. No operation clears it.
- R5: Code 6 adds all 48 bits. Carry is bit 48 of the sum, zero tests all 48 bits and sign is bit 47. Overflow uses the add rule at bit 47.
- R6: Code 8 shifts the low word right arithmetically and code 9 rotates it right. Both load carry from old bit 0, and the rotate moves old bit 0 into bit 31.
- R7: Code 0xA shifts the low word left and code 0xB rotates it left. Both load carry from old bit 31, and the rotate moves it into bit 0.
- R8: Code 0xF rotates the low word left by 8 bits, moving the top byte to the bottom, with carry taken from old bit 24.
- R9: Every operation except code 6 leaves result bits 47:32 equal to accumulator bits 47:32.
- R10: The overflow clear input zeroes the flag at the next edge. If an overflowing add or subtract executes in the same cycle, the flag ends up 1.
- R11: With the execute strobe low, the result and the carry, zero and sign flags hold, while the overflow clear still acts.
- R12: During reset the result and all four flags are 0. Results and flags appear one clock edge after the execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Execute strobe; one operation per high cycle |
| opcode | input | 4 | Operation code |
| acc_in | input | 48 | Accumulator operand |
| prod_in | input | 48 | Product operand |
| ovf_clr | input | 1 | Synchronous clear of the sticky overflow flag |
| result_out | output | 48 | Registered ALU result |
| flag_carry | output | 1 | Carry flag |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_ovf | output | 1 | Sticky overflow flag |

## Verification
Two functions can fall in the same cycle: the overflow clear and an add or subtract that overflows, or one that does not overflow while the flag is already set. The bench drives both pairings directly with operands chosen to overflow or not. It also asserts the clear at random alongside random operations. The bench's behavioural model applies the clear first and then ORs in the new condition, and the flag is compared on the following clock. The clear is also issued with the strobe low, to show that it acts alone while the other flags hold.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

  localparam logic [3:0] OPC_AND   = 4'h1;
  localparam logic [3:0] OPC_OR    = 4'h2;
  localparam logic [3:0] OPC_XOR   = 4'h3;
  localparam logic [3:0] OPC_ADD   = 4'h4;
  localparam logic [3:0] OPC_SUB   = 4'h5;
  localparam logic [3:0] OPC_ADD48 = 4'h6;
  localparam logic [3:0] OPC_SRA   = 4'h8;
  localparam logic [3:0] OPC_ROR   = 4'h9;
  localparam logic [3:0] OPC_SHL   = 4'hA;
  localparam logic [3:0] OPC_ROL   = 4'hB;
  localparam logic [3:0] OPC_ROL8  = 4'hF;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_ARITH = 2'd2,
    GRP_SHIFT = 2'd3
  } alu_grp_e;

  function automatic alu_grp_e opc_group(input logic [3:0] op);
    alu_grp_e g;
    case (op)
      OPC_AND, OPC_OR, OPC_XOR:                      g = GRP_LOGIC;
      OPC_ADD, OPC_SUB, OPC_ADD48:                   g = GRP_ARITH;
      OPC_SRA, OPC_ROR, OPC_SHL, OPC_ROL, OPC_ROL8:  g = GRP_SHIFT;
      default:                                       g = GRP_NONE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/dsp_alu_rstsync.sv
module dsp_alu_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/dsp_alu_logic.sv
module dsp_alu_logic #(
  parameter int LO_W = 32
) (
  input  logic [LO_W-1:0] a_i,
  input  logic [LO_W-1:0] b_i,
  input  logic [1:0]      fn_i,
  output logic [LO_W-1:0] y_o
);

  // fn_i: 1 = and, 2 = or, 3 = xor, 0 = pass a
  for (genvar k = 0; k < LO_W; k++) begin : g_bit
    assign y_o[k] = (fn_i == 2'd1) ? (a_i[k] & b_i[k]) :
                    (fn_i == 2'd2) ? (a_i[k] | b_i[k]) :
                    (fn_i == 2'd3) ? (a_i[k] ^ b_i[k]) : a_i[k];
  end

endmodule

// File: rtl/dsp_alu_arith.sv
module dsp_alu_arith #(
  parameter int LO_W  = 32,
  parameter int ACC_W = 48
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             wide_i,
  output logic [ACC_W-1:0] y_o,
  output logic             carry_o,
  output logic             ovf_o
);

  logic [LO_W-1:0] b_lo_x;
  logic [LO_W:0]   sum_lo;
  logic [ACC_W:0]  sum_w;

  always_comb begin
    // narrow path: subtract as a + ~b + 1
    b_lo_x = b_i[LO_W-1:0] ^ {LO_W{sub_i}};
    sum_lo = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_lo_x} + {{LO_W{1'b0}}, sub_i};
    sum_w  = {1'b0, a_i} + {1'b0, b_i};
    if (wide_i) begin
      y_o     = sum_w[ACC_W-1:0];
      carry_o = sum_w[ACC_W];
      ovf_o   = (a_i[ACC_W-1] == b_i[ACC_W-1]) && (sum_w[ACC_W-1] != a_i[ACC_W-1]);
    end else begin
      y_o     = {a_i[ACC_W-1:LO_W], sum_lo[LO_W-1:0]};
      // for subtract the adder carry-out is the inverse of the borrow
      carry_o = sum_lo[LO_W] ^ sub_i;
      ovf_o   = (a_i[LO_W-1] == b_lo_x[LO_W-1]) && (sum_lo[LO_W-1] != a_i[LO_W-1]);
    end
  end

endmodule

// File: rtl/dsp_alu_shift.sv
module dsp_alu_shift #(
  parameter int LO_W     = 32,
  parameter int ROT_STEP = 8
) (
  input  logic [LO_W-1:0] a_i,
  input  logic [1:0]      kind_i,
  input  logic            byte_rot_i,
  output logic [LO_W-1:0] y_o,
  output logic            carry_o
);

  localparam int SPLIT = LO_W - ROT_STEP;

  always_comb begin
    if (byte_rot_i) begin
      y_o     = {a_i[SPLIT-1:0], a_i[LO_W-1:SPLIT]};
      carry_o = a_i[SPLIT];
    end else begin
      unique case (kind_i)
        2'd0: begin
          y_o     = {a_i[LO_W-1], a_i[LO_W-1:1]};
          carry_o = a_i[0];
        end
        2'd1: begin
          y_o     = {a_i[0], a_i[LO_W-1:1]};
          carry_o = a_i[0];
        end
        2'd2: begin
          y_o     = {a_i[LO_W-2:0], 1'b0};
          carry_o = a_i[LO_W-1];
        end
        default: begin
          y_o     = {a_i[LO_W-2:0], a_i[LO_W-1]};
          carry_o = a_i[LO_W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/dsp_alu_flags.sv
module dsp_alu_flags #(
  parameter int LO_W  = 32,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             upd_i,
  input  logic             wide_i,
  input  logic [ACC_W-1:0] res_i,
  input  logic             carry_i,
  input  logic             ovf_set_i,
  input  logic             ovf_clr_i,
  output logic             c_o,
  output logic             z_o,
  output logic             s_o,
  output logic             v_o
);

  logic c_q, z_q, s_q, v_q;
  logic c_d, z_d, s_d, v_d;
  logic czs_en, v_en;

  always_comb begin
    czs_en = upd_i;
    c_d    = carry_i;
    if (wide_i) begin
      z_d = (res_i == '0);
      s_d = res_i[ACC_W-1];
    end else begin
      z_d = (res_i[LO_W-1:0] == '0);
      s_d = res_i[LO_W-1];
    end
    // clear first, then fold in this cycle's condition
    v_en = ovf_clr_i | ovf_set_i;
    v_d  = (ovf_clr_i ? 1'b0 : v_q) | ovf_set_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
      s_q <= 1'b0;
    end else if (czs_en) begin
      c_q <= c_d;
      z_q <= z_d;
      s_q <= s_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      v_q <= 1'b0;
    end else if (v_en) begin
      v_q <= v_d;
    end
  end

  assign c_o = c_q;
  assign z_o = z_q;
  assign s_o = s_q;
  assign v_o = v_q;

endmodule

// File: rtl/dsp_alu_core.sv
module dsp_alu_core
  import dsp_alu_pkg::*;
#(
  parameter int LO_W     = 32,
  parameter int ACC_W    = 48,
  parameter int ROT_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_en,
  input  logic [3:0]       opcode,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] prod_in,
  input  logic             ovf_clr,
  output logic [ACC_W-1:0] result_out,
  output logic             flag_carry,
  output logic             flag_zero,
  output logic             flag_sign,
  output logic             flag_ovf
);

  localparam int HI_W = ACC_W - LO_W;

  logic             rst_q_n;
  alu_grp_e         grp;
  logic [LO_W-1:0]  lg_y;
  logic [ACC_W-1:0] ar_y;
  logic             ar_c, ar_v;
  logic [LO_W-1:0]  sh_y;
  logic             sh_c;
  logic [ACC_W-1:0] res_d, res_q;
  logic             res_en;
  logic             carry_d;
  logic             upd, wide_op, ovf_set;

  dsp_alu_rstsync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dsp_alu_logic #(.LO_W(LO_W)) u_logic (
    .a_i  (acc_in[LO_W-1:0]),
    .b_i  (prod_in[LO_W-1:0]),
    .fn_i (opcode[1:0]),
    .y_o  (lg_y)
  );

  dsp_alu_arith #(.LO_W(LO_W), .ACC_W(ACC_W)) u_arith (
    .a_i     (acc_in),
    .b_i     (prod_in),
    .sub_i   (opcode == OPC_SUB),
    .wide_i  (opcode == OPC_ADD48),
    .y_o     (ar_y),
    .carry_o (ar_c),
    .ovf_o   (ar_v)
  );

  dsp_alu_shift #(.LO_W(LO_W), .ROT_STEP(ROT_STEP)) u_shift (
    .a_i        (acc_in[LO_W-1:0]),
    .kind_i     (opcode[1:0]),
    .byte_rot_i (opcode == OPC_ROL8),
    .y_o        (sh_y),
    .carry_o    (sh_c)
  );

  // next-state selection
  always_comb begin
    grp     = opc_group(opcode);
    wide_op = (opcode == OPC_ADD48);
    res_en  = exec_en;
    upd     = exec_en && (grp != GRP_NONE);
    ovf_set = exec_en && (grp == GRP_ARITH) && ar_v;
    unique case (grp)
      GRP_LOGIC: begin
        res_d   = {acc_in[ACC_W-1 -: HI_W], lg_y};
        carry_d = 1'b0;
      end
      GRP_ARITH: begin
        res_d   = ar_y;
        carry_d = ar_c;
      end
      GRP_SHIFT: begin
        res_d   = {acc_in[ACC_W-1 -: HI_W], sh_y};
        carry_d = sh_c;
      end
      default: begin
        res_d   = acc_in;
        carry_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  dsp_alu_flags #(.LO_W(LO_W), .ACC_W(ACC_W)) u_flags (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .upd_i     (upd),
    .wide_i    (wide_op),
    .res_i     (res_d),
    .carry_i   (carry_d),
    .ovf_set_i (ovf_set),
    .ovf_clr_i (ovf_clr),
    .c_o       (flag_carry),
    .z_o       (flag_zero),
    .s_o       (flag_sign),
    .v_o       (flag_ovf)
  );

  assign result_out = res_q;

endmodule

// File: rtl/dsp_alu_chk.sv
module dsp_alu_chk
  import dsp_alu_pkg::*;
#(
  parameter int LO_W  = 32,
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             exec_en,
  input logic [3:0]       opcode,
  input logic [ACC_W-1:0] acc_in,
  input logic             ovf_clr,
  input logic [ACC_W-1:0] result_out,
  input logic             flag_carry,
  input logic             flag_zero,
  input logic             flag_sign,
  input logic             flag_ovf
);

  logic is_none, is_logic, is_arith, is_wide, is_narrow;

  always_comb begin
    is_none   = (opc_group(opcode) == GRP_NONE);
    is_logic  = (opc_group(opcode) == GRP_LOGIC);
    is_arith  = (opc_group(opcode) == GRP_ARITH);
    is_wide   = (opcode == OPC_ADD48);
    is_narrow = !is_none && !is_wide;
  end

  assert_nop_pass_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && is_none) |=> (result_out == $past(acc_in)));

  assert_nop_flags_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && is_none) |=> ($stable(flag_carry) && $stable(flag_zero) && $stable(flag_sign)));

  assert_logic_carry_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && is_logic) |=> !flag_carry);

  assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && is_narrow) |=> (flag_zero == (result_out[LO_W-1:0] == '0)));

  assert_sign_wide_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && is_wide) |=> (flag_sign == result_out[ACC_W-1]));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_ovf && !ovf_clr) |=> flag_ovf);

  assert_upper_keep_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && !is_wide) |=> (result_out[ACC_W-1:LO_W] == $past(acc_in[ACC_W-1:LO_W])));

  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovf_clr && !(exec_en && is_arith)) |=> !flag_ovf);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !exec_en |=> ($stable(result_out) && $stable(flag_carry) && $stable(flag_zero) && $stable(flag_sign)));

endmodule

bind dsp_alu_core dsp_alu_chk #(.LO_W(LO_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .exec_en    (exec_en),
  .opcode     (opcode),
  .acc_in     (acc_in),
  .ovf_clr    (ovf_clr),
  .result_out (result_out),
  .flag_carry (flag_carry),
  .flag_zero  (flag_zero),
  .flag_sign  (flag_sign),
  .flag_ovf   (flag_ovf)
);

// File: tb/sim_dsp_alu_core.sv
`timescale 1ns/1ps
module sim_dsp_alu_core;

  logic        clk;
  logic        rst_n;
  logic        exec_en;
  logic [3:0]  opcode;
  logic [47:0] acc_in;
  logic [47:0] prod_in;
  logic        ovf_clr;
  logic [47:0] result_out;
  logic        flag_carry, flag_zero, flag_sign, flag_ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // behavioural reference state
  logic [47:0] m_res;
  logic        m_c, m_z, m_s, m_v;

  dsp_alu_core u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .opcode     (opcode),
    .acc_in     (acc_in),
    .prod_in    (prod_in),
    .ovf_clr    (ovf_clr),
    .result_out (result_out),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero),
    .flag_sign  (flag_sign),
    .flag_ovf   (flag_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic compare(input string tag);
    checks++;
    if (result_out !== m_res || flag_carry !== m_c || flag_zero !== m_z ||
        flag_sign !== m_s || flag_ovf !== m_v) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b z=%b s=%b v=%b expected res=%h c=%b z=%b s=%b v=%b",
               tag, result_out, flag_carry, flag_zero, flag_sign, flag_ovf,
               m_res, m_c, m_z, m_s, m_v);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [47:0] ac, input logic [47:0] p,
                       input logic clr, input logic en);
    logic [63:0] t;
    logic [31:0] a, b, r;
    logic        nc, nv, touch, wide;
    logic [47:0] res;
    if (clr) m_v = 1'b0;
    if (!en) return;
    a = ac[31:0]; b = p[31:0]; r = a;
    nc = 1'b0; nv = 1'b0; touch = 1'b1; wide = 1'b0; res = ac;
    case (op)
      4'h1: r = a & b;
      4'h2: r = a | b;
      4'h3: r = a ^ b;
      4'h4: begin
        t = {32'd0, a} + {32'd0, b}; r = t[31:0]; nc = t[32];
        nv = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'h5: begin
        t = {32'd0, a} - {32'd0, b}; r = t[31:0]; nc = t[32];
        nv = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'h6: begin
        t = {16'd0, ac} + {16'd0, p}; res = t[47:0]; nc = t[48]; wide = 1'b1;
        nv = (ac[47] == p[47]) && (res[47] != ac[47]);
      end
      4'h8: begin r = $unsigned($signed(a) >>> 1); nc = a[0]; end
      4'h9: begin r = (a >> 1) | (a << 31); nc = a[0]; end
      4'hA: begin r = a << 1; nc = a[31]; end
      4'hB: begin r = (a << 1) | (a >> 31); nc = a[31]; end
      4'hF: begin r = (a << 8) | (a >> 24); nc = a[24]; end
      default: touch = 1'b0;
    endcase
    if (touch && !wide) res = {ac[47:32], r};
    m_res = res;
    m_v   = m_v | nv;
    if (touch) begin
      m_c = nc;
      m_z = wide ? (res == 48'd0) : (r == 32'd0);
      m_s = wide ? res[47] : r[31];
    end
  endtask

  // drive at a falling edge, the design takes it at the rising edge, compare at the next falling edge
  task automatic step(input logic [3:0] op, input logic [47:0] ac, input logic [47:0] p,
                      input logic clr, input logic en, input string tag);
    opcode = op; acc_in = ac; prod_in = p; ovf_clr = clr; exec_en = en;
    model(op, ac, p, clr, en);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic en);
    if (!en) return "R11";
    case (op)
      4'h1, 4'h2, 4'h3: return "R2";
      4'h4, 4'h5:       return "R3";
      4'h6:             return "R5";
      4'h8, 4'h9:       return "R6";
      4'hA, 4'hB:       return "R7";
      4'hF:             return "R8";
      default:          return "R1";
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; opcode = 4'h0; acc_in = '0; prod_in = '0; ovf_clr = 1'b0;
    m_res = '0; m_c = 1'b0; m_z = 1'b0; m_s = 1'b0; m_v = 1'b0;
    repeat (3) @(negedge clk);
    compare("R12 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R12 after release");

    // R1 no-ops pass the accumulator and keep flags
    step(4'h0, 48'h1234_5678_9ABC, 48'h1, 1'b0, 1'b1, "R1 code0");
    step(4'h7, 48'hFFFF_8000_0000, 48'h5, 1'b0, 1'b1, "R1 code7");
    step(4'hD, 48'h0000_0000_0000, 48'h5, 1'b0, 1'b1, "R1 codeD");
    // R2 / R9 logic on the low word, upper word kept
    step(4'h1, 48'hABCD_F0F0_F0F0, 48'h0000_0F0F_0F0F, 1'b0, 1'b1, "R2 and zero R9");
    step(4'h2, 48'h1111_8000_0000, 48'hFFFF_0000_0001, 1'b0, 1'b1, "R2 or sign R9");
    step(4'h3, 48'h0000_FFFF_FFFF, 48'h0000_FFFF_FFFE, 1'b0, 1'b1, "R2 xor");
    // R3 carry and borrow
    step(4'h4, 48'h0000_FFFF_FFFF, 48'h0000_0000_0001, 1'b0, 1'b1, "R3 add carry zero");
    step(4'h5, 48'h0000_0000_0000, 48'h0000_0000_0001, 1'b0, 1'b1, "R3 sub borrow");
    step(4'h5, 48'h0000_0000_0005, 48'h0000_0000_0003, 1'b0, 1'b1, "R3 sub no borrow");
    // R4 overflow and stickiness
    step(4'h4, 48'h0000_7FFF_FFFF, 48'h0000_0000_0001, 1'b0, 1'b1, "R4 add overflow");
    step(4'h1, 48'h0000_0000_0003, 48'h0000_0000_0001, 1'b0, 1'b1, "R4 sticky through and");
    step(4'h4, 48'h0000_0000_0001, 48'h0000_0000_0001, 1'b0, 1'b1, "R4 sticky through add");
    step(4'h0, 48'h0, 48'h0, 1'b1, 1'b0, "R10 clear idle R11");
    step(4'h5, 48'h0000_8000_0000, 48'h0000_0000_0001, 1'b0, 1'b1, "R4 sub overflow");
    // R10 clear meeting an arithmetic op in the same cycle
    step(4'h4, 48'h0000_8000_0000, 48'h0000_8000_0000, 1'b1, 1'b1, "R10 clear with overflow");
    step(4'h4, 48'h0000_0000_0002, 48'h0000_0000_0002, 1'b1, 1'b1, "R10 clear with clean add");
    // R5 48-bit add
    step(4'h6, 48'h7FFF_FFFF_FFFF, 48'h0000_0000_0001, 1'b0, 1'b1, "R5 add48 overflow sign");
    step(4'h6, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 1'b1, 1'b1, "R5 add48 carry zero");
    step(4'h6, 48'h0001_0000_0000, 48'h0000_FFFF_FFFF, 1'b0, 1'b1, "R5 add48 nonzero upper");
    // R6 R7 R8 shifts and rotates
    step(4'h8, 48'h5555_8000_0001, 48'h0, 1'b0, 1'b1, "R6 sra");
    step(4'h9, 48'h0000_0000_0001, 48'h0, 1'b0, 1'b1, "R6 ror");
    step(4'hA, 48'h0000_8000_0000, 48'h0, 1'b0, 1'b1, "R7 shl");
    step(4'hB, 48'h0000_8000_0001, 48'h0, 1'b0, 1'b1, "R7 rol");
    step(4'hF, 48'h0000_0100_0000, 48'h0, 1'b0, 1'b1, "R8 rol8 carry");
    step(4'hF, 48'hBEEF_1234_5678, 48'h0, 1'b0, 1'b1, "R8 rol8 no carry R9");
    // R11 idle hold with changing inputs
    step(4'h4, 48'h0000_7FFF_FFFF, 48'h1, 1'b0, 1'b0, "R11 idle add");
    step(4'h1, 48'h0, 48'h0, 1'b0, 1'b0, "R11 idle and");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  op;
      logic [47:0] ac, p;
      logic        en, clr;
      op  = 4'($urandom);
      ac  = {16'($urandom), 32'($urandom)};
      p   = {16'($urandom), 32'($urandom)};
      en  = ($urandom % 8) != 0;
      clr = ($urandom % 8) == 0;
      step(op, ac, p, clr, en, tag_of(op, en));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule